// File: doc/BRIEF.md
# Fractional-N Divider Pair

This block contains the two programmable counters of a fractional-N frequency synthesizer. The reference counter runs on the reference clock. It divides that clock by a 9-bit factor R and emits one comparison pulse per cycle. The main counter runs on the oscillator clock. It divides by an integer N or by N+1, and a small fraction accumulator picks one of the two for each output cycle, so the average ratio is N + k/4. The host writes a 15-bit effective factor E = 4N + k. The upper 13 bits are N and the lower 2 bits are k.

Both counters stay silent after reset until the host delivers a complete factor set. Later settings are captured into a pending copy. That copy reaches the running counter only at a terminal count, and only while the phase detector reports that its charge pump is idle. Because of this, an output period never mixes two settings and is never cut short.

Two monitor outputs either follow static switch bits or carry the two divided pulses for test.

Top module: `fnd_divider_pair`

## Requirements
- R1: After reset, and until a complete factor set has been loaded, `ref_pulse` and `main_pulse` stay low.
- R2: A load strobe seen while `complete` is low is ignored: neither counter starts and no factor is captured. Once a counter has started, it never stops again.
- R3: The reference pulse period is R reference-clock cycles, where R = `ref_factor`. A value below 2 is treated as 2.
- R4: Every main pulse period is either N or N+1 oscillator-clock cycles, with N = `eff_factor[14:2]` and k = `eff_factor[1:0]`.
- R5: Any four consecutive main periods taken under one setting sum to exactly 4N + k, the effective factor.
- R6: An effective factor below 2048 is treated as 2048, so no main period is shorter than 512 cycles.
- R7: Each divided pulse is high for exactly one cycle of its own input clock.
- R8: While `pump_idle` is low, a newly loaded setting is held pending and both periods keep their old values. After `pump_idle` rises, the new setting takes over at a terminal count, and every period in between belongs wholly to either the old or the new setting.
- R9: With `test_mon` high, `sw_a` equals `ref_pulse` and `sw_c` equals `main_pulse`. With `test_mon` low, they equal `sw_a_bit` and `sw_c_bit`.
- R10: A change on the factor inputs without a load strobe has no effect on the periods. The strobe and the factors must be held stable for at least three cycles of the slower clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| ref_clk | input | 1 | Reference clock |
| vco_clk | input | 1 | Oscillator clock feeding the main counter |
| eff_factor | input | 15 | Effective main factor 4N + k |
| ref_factor | input | 9 | Reference divide factor R |
| load | input | 1 | Load strobe, level held for at least three slow-clock cycles |
| complete | input | 1 | High when the factor set on the inputs is complete |
| pump_idle | input | 1 | High when the charge pump is neither sourcing nor sinking |
| test_mon | input | 1 | Routes the divided pulses to the monitor outputs |
| sw_a_bit | input | 1 | Static level for `sw_a` in normal mode |
| sw_c_bit | input | 1 | Static level for `sw_c` in normal mode |
| ref_pulse | output | 1 | Divided reference pulse, one `ref_clk` wide |
| main_pulse | output | 1 | Divided oscillator pulse, one `vco_clk` wide |
| sw_a | output | 1 | Monitor output A |
| sw_c | output | 1 | Monitor output C |

## Verification
Two events can fall in the same oscillator cycle: a synchronized load event capturing a new pending factor, and a terminal count that reloads the counter and may consume the previous pending factor. Randomly timed loads, issued against free-running counters, land on arbitrary phases of the count, including the terminal cycle itself. Each case is judged at the output. Every measured period must equal N or N+1 of a single setting. Once the change has settled, four consecutive periods must sum to the new effective factor, and the reference period must equal the new R.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
  localparam int EFF_W_DEF   = 15;
  localparam int FRAC_W_DEF  = 2;
  localparam int REF_W_DEF   = 9;
  localparam int EFF_MIN_DEF = 2048;
  localparam int REF_MIN_DEF = 2;
  localparam int SYNC_DEF    = 2;

  // true when a programmed factor lies below the smallest legal value
  function automatic logic below_min(input logic [31:0] v, input int lo);
    return v < 32'(lo);
  endfunction

  // one step of the fraction accumulator: {carry, new_acc}
  function automatic logic [FRAC_W_DEF:0] frac_step(input logic [FRAC_W_DEF-1:0] acc,
                                                    input logic [FRAC_W_DEF-1:0] k);
    return {1'b0, acc} + {1'b0, k};
  endfunction
endpackage

// File: rtl/fnd_sync.sv
module fnd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fnd_ref_div.sv
module fnd_ref_div #(
  parameter int REF_W       = fnd_pkg::REF_W_DEF,
  parameter int REF_MIN     = fnd_pkg::REF_MIN_DEF,
  parameter int SYNC_STAGES = fnd_pkg::SYNC_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REF_W-1:0] factor,
  input  logic             load,
  input  logic             complete,
  input  logic             pump_idle,
  output logic             pulse,
  output logic             armed
);
  logic             ld_s, ld_q, idle_s, ld_evt;
  logic [REF_W-1:0] req, act, pend, cnt, mod_use;
  logic             pend_v, armed_q, tc, use_pend;

  fnd_sync #(.STAGES(SYNC_STAGES)) u_ld   (.clk(clk), .rst_n(rst_n), .d(load),      .q(ld_s));
  fnd_sync #(.STAGES(SYNC_STAGES)) u_idle (.clk(clk), .rst_n(rst_n), .d(pump_idle), .q(idle_s));

  assign req      = fnd_pkg::below_min(32'(factor), REF_MIN) ? REF_W'(REF_MIN) : factor;
  assign ld_evt   = ld_s & ~ld_q & complete;
  assign tc       = armed_q && (cnt == '0);
  assign use_pend = pend_v && idle_s;
  assign mod_use  = use_pend ? pend : act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q    <= 1'b0;
      act     <= '0;
      pend    <= '0;
      cnt     <= '0;
      pend_v  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      ld_q <= ld_s;
      if (tc) begin
        cnt <= mod_use - 1'b1;
        if (use_pend) begin
          act    <= pend;
          pend_v <= 1'b0;
        end
      end else if (armed_q) begin
        cnt <= cnt - 1'b1;
      end
      if (ld_evt) begin
        if (!armed_q) begin
          armed_q <= 1'b1;
          act     <= req;
          cnt     <= req - 1'b1;
        end else begin
          pend   <= req;
          pend_v <= 1'b1;
        end
      end
    end
  end

  assign pulse = tc;
  assign armed = armed_q;
endmodule

// File: rtl/fnd_main_div.sv
module fnd_main_div #(
  parameter int EFF_W       = fnd_pkg::EFF_W_DEF,
  parameter int FRAC_W      = fnd_pkg::FRAC_W_DEF,
  parameter int EFF_MIN     = fnd_pkg::EFF_MIN_DEF,
  parameter int SYNC_STAGES = fnd_pkg::SYNC_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EFF_W-1:0] factor,
  input  logic             load,
  input  logic             complete,
  input  logic             pump_idle,
  output logic             pulse,
  output logic             armed
);
  localparam int INT_W = EFF_W - FRAC_W;

  logic              ld_s, ld_q, idle_s, ld_evt;
  logic [EFF_W-1:0]  req;
  logic [INT_W-1:0]  act_n, pend_n, cnt, n_use, reload;
  logic [FRAC_W-1:0] act_k, pend_k, k_use, acc;
  logic [FRAC_W:0]   acc_sum;
  logic              pend_v, armed_q, tc, use_pend, carry;

  fnd_sync #(.STAGES(SYNC_STAGES)) u_ld   (.clk(clk), .rst_n(rst_n), .d(load),      .q(ld_s));
  fnd_sync #(.STAGES(SYNC_STAGES)) u_idle (.clk(clk), .rst_n(rst_n), .d(pump_idle), .q(idle_s));

  assign req      = fnd_pkg::below_min(32'(factor), EFF_MIN) ? EFF_W'(EFF_MIN) : factor;
  assign ld_evt   = ld_s & ~ld_q & complete;
  assign tc       = armed_q && (cnt == '0);
  assign use_pend = pend_v && idle_s;
  assign n_use    = use_pend ? pend_n : act_n;
  assign k_use    = use_pend ? pend_k : act_k;
  assign acc_sum  = fnd_pkg::frac_step(acc, k_use);
  assign carry    = acc_sum[FRAC_W];
  // next modulus minus one: N - 1 + carry
  assign reload   = n_use - {{(INT_W-1){1'b0}}, ~carry};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q    <= 1'b0;
      act_n   <= '0;
      act_k   <= '0;
      pend_n  <= '0;
      pend_k  <= '0;
      cnt     <= '0;
      acc     <= '0;
      pend_v  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      ld_q <= ld_s;
      if (tc) begin
        cnt <= reload;
        acc <= acc_sum[FRAC_W-1:0];
        if (use_pend) begin
          act_n  <= pend_n;
          act_k  <= pend_k;
          pend_v <= 1'b0;
        end
      end else if (armed_q) begin
        cnt <= cnt - 1'b1;
      end
      if (ld_evt) begin
        if (!armed_q) begin
          armed_q <= 1'b1;
          act_n   <= req[EFF_W-1:FRAC_W];
          act_k   <= req[FRAC_W-1:0];
          cnt     <= req[EFF_W-1:FRAC_W] - 1'b1;
          acc     <= '0;
        end else begin
          pend_n <= req[EFF_W-1:FRAC_W];
          pend_k <= req[FRAC_W-1:0];
          pend_v <= 1'b1;
        end
      end
    end
  end

  assign pulse = tc;
  assign armed = armed_q;
endmodule

// File: rtl/fnd_divider_pair.sv
module fnd_divider_pair #(
  parameter int EFF_W       = fnd_pkg::EFF_W_DEF,
  parameter int FRAC_W      = fnd_pkg::FRAC_W_DEF,
  parameter int REF_W       = fnd_pkg::REF_W_DEF,
  parameter int EFF_MIN     = fnd_pkg::EFF_MIN_DEF,
  parameter int REF_MIN     = fnd_pkg::REF_MIN_DEF,
  parameter int SYNC_STAGES = fnd_pkg::SYNC_DEF
) (
  input  logic             rst_n,
  input  logic             ref_clk,
  input  logic             vco_clk,
  input  logic [EFF_W-1:0] eff_factor,
  input  logic [REF_W-1:0] ref_factor,
  input  logic             load,
  input  logic             complete,
  input  logic             pump_idle,
  input  logic             test_mon,
  input  logic             sw_a_bit,
  input  logic             sw_c_bit,
  output logic             ref_pulse,
  output logic             main_pulse,
  output logic             sw_a,
  output logic             sw_c
);
  logic ref_armed_w, main_armed_w;

  fnd_ref_div #(.REF_W(REF_W), .REF_MIN(REF_MIN), .SYNC_STAGES(SYNC_STAGES)) u_ref (
    .clk(ref_clk), .rst_n(rst_n), .factor(ref_factor), .load(load),
    .complete(complete), .pump_idle(pump_idle), .pulse(ref_pulse), .armed(ref_armed_w));

  fnd_main_div #(.EFF_W(EFF_W), .FRAC_W(FRAC_W), .EFF_MIN(EFF_MIN),
                 .SYNC_STAGES(SYNC_STAGES)) u_main (
    .clk(vco_clk), .rst_n(rst_n), .factor(eff_factor), .load(load),
    .complete(complete), .pump_idle(pump_idle), .pulse(main_pulse), .armed(main_armed_w));

  assign sw_a = test_mon ? ref_pulse  : sw_a_bit;
  assign sw_c = test_mon ? main_pulse : sw_c_bit;
endmodule

// File: rtl/fnd_checks.sv
module fnd_checks #(
  parameter int MIN_N   = fnd_pkg::EFF_MIN_DEF >> fnd_pkg::FRAC_W_DEF,
  parameter int REF_MIN = fnd_pkg::REF_MIN_DEF
) (
  input logic rst_n,
  input logic vco_clk,
  input logic ref_clk,
  input logic main_pulse,
  input logic ref_pulse,
  input logic main_armed,
  input logic ref_armed
);
  logic [15:0] gap_m, gap_r;
  logic        seen_m, seen_r;

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_m  <= '0;
      seen_m <= 1'b0;
    end else if (main_pulse) begin
      gap_m  <= '0;
      seen_m <= 1'b1;
    end else if (gap_m != 16'hFFFF) begin
      gap_m <= gap_m + 1'b1;
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_r  <= '0;
      seen_r <= 1'b0;
    end else if (ref_pulse) begin
      gap_r  <= '0;
      seen_r <= 1'b1;
    end else if (gap_r != 16'hFFFF) begin
      gap_r <= gap_r + 1'b1;
    end
  end

  AST_MAIN_MIN_GAP: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (main_pulse && seen_m) |-> (gap_m >= 16'(MIN_N - 1))); // R6
  AST_REF_MIN_GAP: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (ref_pulse && seen_r) |-> (gap_r >= 16'(REF_MIN - 1))); // R3
  AST_MAIN_ONE_WIDE: assert property (@(posedge vco_clk) disable iff (!rst_n)
    main_pulse |=> !main_pulse); // R7
  AST_REF_ONE_WIDE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse); // R7
  AST_MAIN_STAYS_ARMED: assert property (@(posedge vco_clk) disable iff (!rst_n)
    main_armed |=> main_armed); // R2
  AST_REF_STAYS_ARMED: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ref_armed |=> ref_armed); // R2
endmodule

bind fnd_divider_pair fnd_checks u_chk (
  .rst_n(rst_n), .vco_clk(vco_clk), .ref_clk(ref_clk),
  .main_pulse(main_pulse), .ref_pulse(ref_pulse),
  .main_armed(main_armed_w), .ref_armed(ref_armed_w));

// File: tb/sim_fnd_divider_pair.sv
module sim_fnd_divider_pair;
  logic        rst_n = 1'b0, ref_clk = 1'b0, vco_clk = 1'b0;
  logic [14:0] eff_factor = '0;
  logic [8:0]  ref_factor = '0;
  logic        load = 1'b0, complete = 1'b0, pump_idle = 1'b1;
  logic        test_mon = 1'b0, sw_a_bit = 1'b1, sw_c_bit = 1'b0;
  logic        ref_pulse, main_pulse, sw_a, sw_c;

  int total = 0, bad = 0;
  int vcyc = 0, mlast = 0, mper = 0, mcount = 0, mdouble = 0;
  int rcyc = 0, rlast = 0, rper = 0, rcount = 0, rdouble = 0;
  bit mprev = 0, rprev = 0, mux_watch = 0;
  int muxerr = 0, swc_hi = 0;

  fnd_divider_pair u0 (
    .rst_n(rst_n), .ref_clk(ref_clk), .vco_clk(vco_clk),
    .eff_factor(eff_factor), .ref_factor(ref_factor), .load(load),
    .complete(complete), .pump_idle(pump_idle), .test_mon(test_mon),
    .sw_a_bit(sw_a_bit), .sw_c_bit(sw_c_bit), .ref_pulse(ref_pulse),
    .main_pulse(main_pulse), .sw_a(sw_a), .sw_c(sw_c));

  always #5 vco_clk = ~vco_clk;
  always #7 ref_clk = ~ref_clk;

  always @(negedge vco_clk) begin
    vcyc++;
    if (main_pulse) begin
      if (mcount > 0) mper = vcyc - mlast;
      mlast = vcyc;
      mcount++;
      if (mprev) mdouble++;
    end
    mprev = main_pulse;
    if (mux_watch) begin
      if (sw_c !== main_pulse || sw_a !== ref_pulse) muxerr++;
      if (sw_c) swc_hi++;
    end
  end

  always @(negedge ref_clk) begin
    rcyc++;
    if (ref_pulse) begin
      if (rcount > 0) rper = rcyc - rlast;
      rlast = rcyc;
      rcount++;
      if (rprev) rdouble++;
    end
    rprev = ref_pulse;
  end

  function automatic int exp_eff(int e);
    return (e < 2048) ? 2048 : e;
  endfunction

  function automatic int exp_ref(int r);
    return (r < 2) ? 2 : r;
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wait_main(int n);
    int target = mcount + n;
    while (mcount < target) @(negedge vco_clk);
  endtask

  task automatic wait_ref(int n);
    int target = rcount + n;
    while (rcount < target) @(negedge ref_clk);
  endtask

  task automatic do_load(int e, int r, bit comp);
    @(negedge vco_clk);
    eff_factor = 15'(e);
    ref_factor = 9'(r);
    complete   = comp;
    load       = 1'b1;
    repeat (8) @(negedge vco_clk);
    load = 1'b0;
    repeat (8) @(negedge vco_clk);
  endtask

  // R4 each period N or N+1, R5 four-period sum equals 4N+k
  task automatic check_main(int e, string tag);
    int ee = exp_eff(e);
    int n  = ee >> 2;
    int sum = 0, off = 0;
    wait_main(3);
    for (int i = 0; i < 4; i++) begin
      wait_main(1);
      sum += mper;
      if (mper != n && mper != n + 1) off++;
    end
    chk(off == 0, $sformatf("R4 %s periods outside N/N+1", tag), off, 0);
    chk(sum == ee, $sformatf("R5 %s four-period sum", tag), sum, ee);
  endtask

  task automatic check_ref(int r, string tag);
    int rr = exp_ref(r);
    wait_ref(3);
    wait_ref(1);
    chk(rper == rr, $sformatf("R3 %s reference period", tag), rper, rr);
  endtask

  initial begin
    int seed_init;
    seed_init = $urandom(32'd2024);
    repeat (5) @(negedge vco_clk);
    rst_n = 1'b1;

    // R1: silent before any complete load; R9 normal mode follows bits
    repeat (3000) @(negedge vco_clk);
    chk(mcount == 0, "R1 main silent before load", mcount, 0);
    chk(rcount == 0, "R1 ref silent before load", rcount, 0);
    chk(sw_a == sw_a_bit && sw_c == sw_c_bit, "R9 normal mode monitor", {sw_a, sw_c}, {sw_a_bit, sw_c_bit});

    // R2: incomplete load ignored
    do_load(2300, 10, 1'b0);
    repeat (3000) @(negedge vco_clk);
    chk(mcount == 0 && rcount == 0, "R2 incomplete load ignored", mcount + rcount, 0);

    do_load(2050, 5, 1'b1);
    check_main(2050, "first");
    check_ref(5, "first");

    // R10: factor change without strobe has no effect
    eff_factor = 15'd3001;
    ref_factor = 9'd33;
    check_main(2050, "R10 no strobe");
    check_ref(5, "R10 no strobe");

    // R3 clamp of reference factor, R6 clamp of main factor
    do_load(100, 1, 1'b1);
    check_main(100, "R6 clamp");
    check_ref(1, "R3 clamp one");
    do_load(2103, 0, 1'b1);
    check_main(2103, "k3");
    check_ref(0, "R3 clamp zero");

    // R8: held while pump busy, applied after idle
    pump_idle = 1'b0;
    do_load(2401, 20, 1'b1);
    check_main(2103, "R8 held");
    check_ref(2, "R8 held");
    pump_idle = 1'b1;
    check_main(2401, "R8 applied");
    check_ref(20, "R8 applied");

    // R9: test mode routes pulses
    test_mon = 1'b1;
    mux_watch = 1;
    wait_main(3);
    mux_watch = 0;
    test_mon = 1'b0;
    chk(muxerr == 0, "R9 test mode mismatches", muxerr, 0);
    chk(swc_hi == 3, "R9 main pulses seen on sw_c", swc_hi, 3);

    // random settings, loads land on arbitrary counter phases
    for (int i = 0; i < 5; i++) begin
      int e = 2048 + int'($urandom % 350);
      int r = 2 + int'($urandom % 60);
      do_load(e, r, 1'b1);
      check_main(e, "random");
      check_ref(r, "random");
    end

    // R7: single-cycle pulses throughout
    chk(mdouble == 0, "R7 main pulse width", mdouble, 0);
    chk(rdouble == 0, "R7 ref pulse width", rdouble, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge vco_clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule